// File: doc/BRIEF.md
# Register File with Per-Field Reset Sources

This block is a small bank of five 32-bit control registers that software reaches over a simple APB-style port. Each register is split into a low half and a high half, both 16-bit fields that software can read and write. A single write sets both halves of the addressed register at once. A read returns the high half above the low half and changes nothing.

The low half of each register is cleared by a reset line of its own, and those lines differ in polarity and timing. One is the global synchronous active-high reset. Two are separate synchronous lines, one active-high and one active-low. The other two are asynchronous, one active-high and one active-low. Every line is first turned into an active-high condition. The asynchronous lines then sit in the sensitivity list of their flops, on the rising or the falling edge as their polarity requires.

All high halves share one synchronous active-high reset. In the last register, the high half takes its reset value from a live 16-bit input rather than from a constant. The bus request and response flops have their own active-high reset, kept apart from the field resets.

Top module: `regfile_top`

## Requirements
- R1: Registers 0 to 4 sit at byte addresses 0x00, 0x04, 0x08, 0x0C and 0x10. Bits 15:0 of each register hold the low field and bits 31:16 hold the high field. A write stores both fields of the addressed register, and a read returns {high, low}.
- R2: While `rst_glb` is high at a clock edge, register 0's low field becomes 0x1234. No other field responds to `rst_glb`.
- R3: Register 1's low field becomes 0x1234 at a clock edge where `rst_r1_s` is high. Register 3's low field becomes 0x1234 at a clock edge where `rst_r3_sn` is low. Neither line affects any other field.
- R4: Register 2's low field becomes 0x1234 as soon as `rst_r2_a` rises, with no clock edge needed. Register 4's low field does the same as soon as `rst_r4_an` falls. A pulse shorter than one clock period still clears the field, and the value holds after the pulse ends.
- R5: At a clock edge where `rst_hi` is high, the high fields of registers 0 to 3 become 0x5678. `rst_hi` is the only reset that touches any high field.
- R6: At a clock edge where `rst_hi` is high, register 4's high field loads the value on `hi4_seed` at that edge.
- R7: While `rst_bus` is high, `pready`, `pslverr` and `prdata` are zero and any transfer in flight is dropped. `rst_bus` leaves every field unchanged.
- R8: An address that is not one of the five aligned offsets gives `pslverr`=1 and `prdata`=0. A write to such an address changes no field.
- R9: A transfer has a setup cycle with `psel`=1 and `penable`=0, followed by an access cycle with `penable`=1. `pready` is high during the cycle after the access cycle, and for that cycle only. `prdata` is zero in the response to a write.
- R10: A read does not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_glb | input | 1 | Global synchronous active-high reset (register 0 low field) |
| rst_bus | input | 1 | Synchronous active-high reset for the bus request and response flops |
| rst_r1_s | input | 1 | Synchronous active-high reset, register 1 low field |
| rst_r2_a | input | 1 | Asynchronous active-high reset, register 2 low field |
| rst_r3_sn | input | 1 | Synchronous active-low reset, register 3 low field |
| rst_r4_an | input | 1 | Asynchronous active-low reset, register 4 low field |
| rst_hi | input | 1 | Shared synchronous active-high reset for all high fields |
| hi4_seed | input | 16 | Reset value for register 4's high field |
| psel | input | 1 | Select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `pready` is high |
| pready | output | 1 | One-cycle response strobe |
| pslverr | output | 1 | Error for an address outside the map |

## Verification
Take the edge that closes the setup cycle as edge 1. The request is captured at edge 1. The write lands, or the read data is registered, at edge 2. `pready` then stays high until edge 3. The bench drives on falling edges. It samples the response at the falling edge just after edge 2, and it also checks that `pready` was still low one falling edge earlier. A synchronous reset pulse is held across exactly one rising edge, and the field is read back through the bus after that. An asynchronous pulse is raised and dropped between two rising edges, so that only the edge-triggered path can clear the field.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int unsigned NREG    = 5;
    localparam int unsigned FIELD_W = 16;
    localparam int unsigned DATA_W  = 2 * FIELD_W;
    localparam int unsigned BYTE_SH = $clog2(DATA_W / 8);
    localparam int unsigned ADDR_W  = $clog2(NREG * (DATA_W / 8));
    localparam int unsigned IDX_W   = ADDR_W - BYTE_SH;

    localparam logic [FIELD_W-1:0] LO_INIT = 16'h1234;
    localparam logic [FIELD_W-1:0] HI_INIT = 16'h5678;

    typedef enum logic [1:0] {
        RK_SYNC_HIGH,
        RK_SYNC_LOW,
        RK_ASYNC_HIGH,
        RK_ASYNC_LOW
    } rst_kind_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    // Reset style of the low field in each register.
    function automatic rst_kind_e lo_kind(input int unsigned idx);
        case (idx)
            2:       return RK_ASYNC_HIGH;
            3:       return RK_SYNC_LOW;
            4:       return RK_ASYNC_LOW;
            default: return RK_SYNC_HIGH;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BYTE_SH];
    endfunction

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a);
        return (a[BYTE_SH-1:0] == '0) && (int'(addr_idx(a)) < NREG);
    endfunction

endpackage

// File: rtl/regfile_field.sv
module regfile_field
    import regfile_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter rst_kind_e   KIND = RK_SYNC_HIGH
) (
    input  logic         clk,
    input  logic         rst_src,
    input  logic [W-1:0] rst_val,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    generate
        if (KIND == RK_ASYNC_HIGH) begin : g_ah
            always_ff @(posedge clk or posedge rst_src) begin
                if (rst_src)  q <= rst_val;
                else if (we)  q <= wdata;
            end
        end else if (KIND == RK_ASYNC_LOW) begin : g_al
            always_ff @(posedge clk or negedge rst_src) begin
                if (!rst_src) q <= rst_val;
                else if (we)  q <= wdata;
            end
        end else begin : g_sync
            logic rst_act;
            assign rst_act = (KIND == RK_SYNC_LOW) ? ~rst_src : rst_src;
            always_ff @(posedge clk) begin
                if (rst_act)  q <= rst_val;
                else if (we)  q <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/regfile_bus.sv
module regfile_bus
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_bus,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic              req_v,
    output req_t              req,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);

    logic active;

    always_ff @(posedge clk) begin
        if (rst_bus) begin
            active  <= 1'b0;
            req_v   <= 1'b0;
            req     <= '0;
            pready  <= 1'b0;
            pslverr <= 1'b0;
            prdata  <= '0;
        end else begin
            req_v   <= 1'b0;
            if (psel && !penable && !active) begin
                active <= 1'b1;
                req_v  <= 1'b1;
                req    <= '{wr: pwrite, addr: paddr, wdata: pwdata};
            end else if (pready) begin
                active <= 1'b0;
            end
            pready  <= req_v;
            pslverr <= req_v && rd_err;
            prdata  <= (req_v && !req.wr && !rd_err) ? rd_data : '0;
        end
    end

endmodule

// File: rtl/regfile_rdmux.sv
module regfile_rdmux
    import regfile_pkg::*;
(
    input  logic [NREG*DATA_W-1:0] words,
    input  logic [ADDR_W-1:0]      addr,
    output logic [DATA_W-1:0]      data,
    output logic                   err
);

    always_comb begin
        data = '0;
        err  = !addr_hit(addr);
        for (int i = 0; i < NREG; i++) begin
            if (!err && (int'(addr_idx(addr)) == i))
                data = words[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/regfile_top.sv
module regfile_top
    import regfile_pkg::*;
(
    input  logic               clk,
    input  logic               rst_glb,
    input  logic               rst_bus,
    input  logic               rst_r1_s,
    input  logic               rst_r2_a,
    input  logic               rst_r3_sn,
    input  logic               rst_r4_an,
    input  logic               rst_hi,
    input  logic [FIELD_W-1:0] hi4_seed,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr
);

    logic                   req_v;
    req_t                   req;
    logic [DATA_W-1:0]      rd_data;
    logic                   rd_err;
    logic [NREG-1:0]        wr_en;
    logic [NREG-1:0]        lo_src;
    logic [NREG*DATA_W-1:0] view_flat;

    assign lo_src = {rst_r4_an, rst_r3_sn, rst_r2_a, rst_r1_s, rst_glb};

    regfile_bus u_bus (
        .clk     (clk),
        .rst_bus (rst_bus),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .req_v   (req_v),
        .req     (req),
        .rd_data (rd_data),
        .rd_err  (rd_err),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr)
    );

    regfile_rdmux u_rd (
        .words (view_flat),
        .addr  (req.addr),
        .data  (rd_data),
        .err   (rd_err)
    );

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            assign wr_en[i] = req_v && req.wr && !rd_err
                              && (int'(addr_idx(req.addr)) == i);

            regfile_field #(.W(FIELD_W), .KIND(lo_kind(i))) u_lo (
                .clk     (clk),
                .rst_src (lo_src[i]),
                .rst_val (LO_INIT),
                .we      (wr_en[i]),
                .wdata   (req.wdata[FIELD_W-1:0]),
                .q       (view_flat[i*DATA_W +: FIELD_W])
            );

            regfile_field #(.W(FIELD_W), .KIND(RK_SYNC_HIGH)) u_hi (
                .clk     (clk),
                .rst_src (rst_hi),
                .rst_val ((i == NREG-1) ? hi4_seed : HI_INIT),
                .we      (wr_en[i]),
                .wdata   (req.wdata[DATA_W-1:FIELD_W]),
                .q       (view_flat[i*DATA_W+FIELD_W +: FIELD_W])
            );
        end
    endgenerate

endmodule

// File: rtl/regfile_checker.sv
module regfile_checker
    import regfile_pkg::*;
(
    input logic                   clk,
    input logic                   rst_bus,
    input logic                   rst_glb,
    input logic                   rst_r3_sn,
    input logic                   rst_r4_an,
    input logic                   rst_hi,
    input logic [FIELD_W-1:0]     hi4_seed,
    input logic                   pready,
    input logic                   pslverr,
    input logic [DATA_W-1:0]      prdata,
    input logic [NREG*DATA_W-1:0] view
);

    AST_GLB_CLEARS_R0: assert property (@(posedge clk) disable iff (rst_bus)
        rst_glb |=> view[0 +: FIELD_W] == LO_INIT); // R2

    AST_LOW_SYNC_R3: assert property (@(posedge clk) disable iff (rst_bus)
        !rst_r3_sn |=> view[3*DATA_W +: FIELD_W] == LO_INIT); // R3

    AST_ASYNC_LOW_R4: assert property (@(posedge clk) disable iff (rst_bus)
        !rst_r4_an |-> view[4*DATA_W +: FIELD_W] == LO_INIT); // R4

    AST_HI_SHARED: assert property (@(posedge clk) disable iff (rst_bus)
        rst_hi |=> (view[0*DATA_W+FIELD_W +: FIELD_W] == HI_INIT)
                && (view[1*DATA_W+FIELD_W +: FIELD_W] == HI_INIT)
                && (view[2*DATA_W+FIELD_W +: FIELD_W] == HI_INIT)
                && (view[3*DATA_W+FIELD_W +: FIELD_W] == HI_INIT)); // R5

    AST_HI_SEED: assert property (@(posedge clk) disable iff (rst_bus)
        rst_hi |=> view[4*DATA_W+FIELD_W +: FIELD_W] == $past(hi4_seed)); // R6

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst_bus)
        (pready && pslverr) |-> prdata == '0); // R8

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst_bus)
        pready |=> !pready); // R9

endmodule

bind regfile_top regfile_checker u_chk (
    .clk       (clk),
    .rst_bus   (rst_bus),
    .rst_glb   (rst_glb),
    .rst_r3_sn (rst_r3_sn),
    .rst_r4_an (rst_r4_an),
    .rst_hi    (rst_hi),
    .hi4_seed  (hi4_seed),
    .pready    (pready),
    .pslverr   (pslverr),
    .prdata    (prdata),
    .view      (view_flat)
);

// File: tb/regfile_top_test.sv
`timescale 1ns/100ps
module regfile_top_test;
    import regfile_pkg::*;

    logic clk;
    logic rst_glb, rst_bus, rst_r1_s, rst_r2_a, rst_r3_sn, rst_r4_an, rst_hi;
    logic [15:0] hi4_seed;
    logic psel, penable, pwrite;
    logic [4:0]  paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic pready, pslverr;

    int n_chk  = 0;
    int n_fail = 0;

    regfile_top uut (
        .clk(clk), .rst_glb(rst_glb), .rst_bus(rst_bus), .rst_r1_s(rst_r1_s),
        .rst_r2_a(rst_r2_a), .rst_r3_sn(rst_r3_sn), .rst_r4_an(rst_r4_an),
        .rst_hi(rst_hi), .hi4_seed(hi4_seed), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h00, 32'h0,          32'h5678_1234, 1'b0}, // R1 R2 R5
        '{1'b0, 5'h04, 32'h0,          32'h5678_1234, 1'b0}, // R3
        '{1'b0, 5'h08, 32'h0,          32'h5678_1234, 1'b0}, // R4
        '{1'b0, 5'h0C, 32'h0,          32'h5678_1234, 1'b0}, // R3
        '{1'b0, 5'h10, 32'h0,          32'hABCD_1234, 1'b0}, // R6
        '{1'b0, 5'h14, 32'h0,          32'h0,         1'b1}, // R8
        '{1'b0, 5'h02, 32'h0,          32'h0,         1'b1}, // R8
        '{1'b1, 5'h00, 32'hAAAA_5555,  32'h0,         1'b0}, // R1 R9
        '{1'b0, 5'h00, 32'h0,          32'hAAAA_5555, 1'b0}, // R1
        '{1'b1, 5'h14, 32'hFFFF_FFFF,  32'h0,         1'b1}, // R8
        '{1'b0, 5'h10, 32'h0,          32'hABCD_1234, 1'b0}, // R8
        '{1'b1, 5'h10, 32'h0BAD_0001,  32'h0,         1'b0}, // R1
        '{1'b0, 5'h10, 32'h0,          32'h0BAD_0001, 1'b0}, // R1 R10
        '{1'b0, 5'h10, 32'h0,          32'h0BAD_0001, 1'b0}  // R10
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One transfer; response sampled at the falling edge after the second rising edge.
    task automatic xfer(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        check(pready == 1'b0, "R9 early ready", {31'b0, pready}, 32'h0);
        @(negedge clk);
        check(pready == 1'b1, "R9 ready timing", {31'b0, pready}, 32'h1);
        rd = prdata; er = pslverr;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v; logic e;
        xfer(1'b0, a, 32'h0, v, e);
        check(v == exp && !e, req, v, exp);
    endtask

    task automatic clear_all();
        logic [31:0] v; logic e;
        for (int i = 0; i < 5; i++) xfer(1'b1, 5'(i*4), 32'h0, v, e);
    endtask

    task automatic expect_lo(input int which, input string req);
        for (int i = 0; i < 5; i++)
            rd_chk(5'(i*4), (i == which) ? 32'h0000_1234 : 32'h0, req);
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v; logic e;
        psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
        rst_glb = 1; rst_bus = 1; rst_r1_s = 1; rst_r2_a = 1;
        rst_r3_sn = 0; rst_r4_an = 0; rst_hi = 1; hi4_seed = 16'hABCD;
        repeat (3) @(negedge clk);
        check(pready == 0 && pslverr == 0 && prdata == 0, "R7 reset outputs",
              prdata, 32'h0);
        rst_glb = 0; rst_bus = 0; rst_r1_s = 0; rst_r2_a = 0;
        rst_r3_sn = 1; rst_r4_an = 1; rst_hi = 0;

        for (int k = 0; k < NV; k++) begin
            xfer(VEC[k].wr, VEC[k].addr, VEC[k].data, v, e);
            check(v == VEC[k].exp && e == VEC[k].err, "R1/R8/R10 vector", v, VEC[k].exp);
        end

        clear_all();
        @(negedge clk); rst_glb = 1; @(negedge clk); rst_glb = 0;
        expect_lo(0, "R2 global reset");

        clear_all();
        @(negedge clk); rst_r1_s = 1; @(negedge clk); rst_r1_s = 0;
        expect_lo(1, "R3 reg1 sync high");

        clear_all();
        @(negedge clk); rst_r3_sn = 0; @(negedge clk); rst_r3_sn = 1;
        expect_lo(3, "R3 reg3 sync low");

        clear_all();
        @(negedge clk); #0.5 rst_r2_a = 1; #0.5 rst_r2_a = 0;
        expect_lo(2, "R4 reg2 async high");

        clear_all();
        @(negedge clk); #0.5 rst_r4_an = 0; #0.5 rst_r4_an = 1;
        expect_lo(4, "R4 reg4 async low");

        clear_all();
        @(negedge clk); rst_hi = 1; hi4_seed = 16'h3210;
        @(negedge clk); rst_hi = 0; hi4_seed = 16'h7777;
        for (int i = 0; i < 4; i++) rd_chk(5'(i*4), 32'h5678_0000, "R5 shared high reset");
        rd_chk(5'h10, 32'h3210_0000, "R6 seeded high field");

        xfer(1'b1, 5'h00, 32'h1111_2222, v, e);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 5'h00;
        @(negedge clk); penable = 1; rst_bus = 1;
        @(negedge clk);
        check(pready == 0 && prdata == 0, "R7 bus reset drops transfer", prdata, 32'h0);
        psel = 0; penable = 0; rst_bus = 0;
        rd_chk(5'h00, 32'h1111_2222, "R7 fields kept across bus reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule